// File: doc/BRIEF.md
# Serial EEPROM Target with Per-Block Write Locking

This block is a two-wire serial (I2C) target that serves a 512-byte byte-addressed store. It watches SCL and SDA through a system clock that runs far faster than the bus. It recognises start and stop conditions and decodes a 7-bit target address whose three low bits come from static strap inputs. After that it runs write phases (a two-byte word address, then data) or read phases (sequential bytes from an auto-incrementing pointer). SDA is open-drain: the block only ever asks for the line to be pulled low.

The store is split into four 128-byte blocks. Each of the lower three blocks has its own write lock, which can be set and cleared again at any time. The lock bits are reached through a second target address, the control address. Block 3 (bytes 384–511) can never be locked. Bytes 256–319 form a reserved window that always reads as zero. A write transaction closed by a stop starts an internal write-cycle interval. During that interval the block refuses to acknowledge either of its addresses. If SCL stays low too long during a transaction, the block drops the transaction and releases SDA.

Top module: `prot_eeprom`

## Requirements
- R1: The block acknowledges target address {1010, strap} (memory) and {0110, strap} (control), with strap as the low three bits. Any other address is not acknowledged, and the block then leaves SDA released until the next start or stop. The block only begins pulling SDA low while SCL is low.
- R2: A memory write carries two word-address bytes, the first holding address bit 8 in its bit 0 and the second holding bits 7:0. Every following data byte is acknowledged and stored at the pointer, which then advances by one.
- R3: A memory read returns the byte at the pointer and advances the pointer by one. Reads continue while the controller acknowledges. The pointer wraps from 511 to 0 for both reads and writes.
- R4: Bytes 256–319 always read as 00h, and data written to them is discarded. Byte 255 and byte 320 behave as ordinary storage.
- R5: Each byte written to the control address updates one lock: bits 1:0 select the block and bit 7 is the new lock value (1 locks, 0 unlocks). Selecting block 3 has no effect. A read of the control address returns a byte whose bit n is the lock of block n, with bits 7:3 zero.
- R6: A data byte aimed at a locked block is acknowledged but not stored. Bytes in unlocked blocks are stored normally.
- R7: A stop that closes a write carrying at least one data or control byte starts a busy interval of WR_CYCLES clocks. During that interval neither target address is acknowledged. After it, both are acknowledged again.
- R8: If SCL stays low for TMO_CYCLES clocks during a transaction, the block releases SDA and returns to idle. The next transaction is served normally.
- R9: After reset SDA is released and every block is unlocked.
- R10: A start seen in the middle of any byte abandons that byte and begins a new address phase.
- R11: When the controller does not acknowledge a read byte, the block releases SDA and sends nothing more until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 3 | Static strap pins, the low three bits of both target addresses |
| sda_oe | output | 1 | High to pull SDA low; low to release the line |

## Verification
The hardest state to reach from the ports is the stuck-clock recovery while the block itself is holding SDA low in the middle of a read byte. The bench stores a byte whose top bit is zero and points the pointer at it. It then opens a read and stops toggling SCL right after the address acknowledge, so the first data bit is being driven low when the clock freezes. The busy window is the other awkward case. It is reached by issuing address attempts right after the stop of a write, before the interval runs out, and then repeating them once it has passed.

// File: rtl/eep_pkg.sv
package eep_pkg;

  // Bus-side sequencing states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_TXNEXT,
    ST_WAIT
  } eep_state_t;

  // Meaning of the byte currently being received
  typedef enum logic [2:0] {
    RL_DEV,
    RL_AHI,
    RL_ALO,
    RL_DATA,
    RL_CTRL
  } eep_role_t;

  localparam logic [3:0] MEM_CODE = 4'b1010;
  localparam logic [3:0] CTL_CODE = 4'b0110;

endpackage

// File: rtl/eep_bus_sense.sv
module eep_bus_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/eep_timers.sv
module eep_timers #(
  parameter int WR_CYCLES  = 1000000,
  parameter int TMO_CYCLES = 6000000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic active,
  input  logic wr_go,
  output logic busy,
  output logic tmo_fire
);

  localparam int WW = $clog2(WR_CYCLES + 1);
  localparam int TW = $clog2(TMO_CYCLES + 1);

  logic [WW-1:0] wr_cnt;
  logic [TW-1:0] low_cnt;

  // Internal write-cycle interval
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt <= '0;
    end else if (wr_go) begin
      wr_cnt <= WW'(WR_CYCLES);
    end else if (wr_cnt != '0) begin
      wr_cnt <= wr_cnt - 1'b1;
    end
  end

  // Length of the current SCL-low stretch inside a transaction
  always_ff @(posedge clk) begin
    if (rst || !active || scl_s) begin
      low_cnt <= '0;
    end else if (low_cnt != TW'(TMO_CYCLES)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign busy     = (wr_cnt != '0);
  assign tmo_fire = active & ~scl_s & (low_cnt == TW'(TMO_CYCLES));

endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] ram [DEPTH];

  // Single-port, read-first, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) begin
      ram[addr] <= wdata;
    end
    rdata <= ram[addr];
  end

endmodule

// File: rtl/prot_eeprom.sv
module prot_eeprom
  import eep_pkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int BLOCK_BYTES = 128,
  parameter int PROT_BLOCKS = 3,
  parameter int RSV_LO      = 256,
  parameter int RSV_HI      = 319,
  parameter int WR_CYCLES   = 1000000,
  parameter int TMO_CYCLES  = 6000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe
);

  // MEM_BYTES must be a power of two between 512 and 65536
  localparam int AW   = $clog2(MEM_BYTES);
  localparam int NBLK = MEM_BYTES / BLOCK_BYTES;
  localparam int BW   = $clog2(NBLK);
  localparam int OFFW = $clog2(BLOCK_BYTES);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, tmo_fire, wr_go;

  eep_state_t    state;
  eep_role_t     role;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg;
  logic [AW-1:0] ptr;
  logic          is_ctrl;
  logic          rd_mode;
  logic          sda_oe_q;
  logic          wrote;

  logic          byte_done;
  logic          tx_load;
  logic          mem_hit;
  logic          ctl_hit;
  logic          rsv_hit;
  logic [BW-1:0] cur_blk;
  logic [NBLK-1:0] lock_v;
  logic          mem_we;
  logic [7:0]    mem_rdata;
  logic [7:0]    rd_byte;
  logic          ctl_wr;
  logic [BW-1:0] ctl_idx;
  logic          ctl_set;

  eep_bus_sense #(.STAGES(SYNC_STAGES)) u_sense (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  eep_timers #(.WR_CYCLES(WR_CYCLES), .TMO_CYCLES(TMO_CYCLES)) u_timers (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .active   (state != ST_IDLE),
    .wr_go    (wr_go),
    .busy     (busy),
    .tmo_fire (tmo_fire)
  );

  eep_mem #(.DEPTH(MEM_BYTES), .DW(8)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (ptr),
    .wdata (shreg),
    .rdata (mem_rdata)
  );

  // Per-block lock flags; blocks at or above PROT_BLOCKS are always open
  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    if (g < PROT_BLOCKS) begin : g_lock
      logic lock_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          lock_q <= 1'b0;
        end else if (ctl_wr && (ctl_idx == BW'(g))) begin
          lock_q <= ctl_set;
        end
      end
      assign lock_v[g] = lock_q;
    end else begin : g_open
      assign lock_v[g] = 1'b0;
    end
  end

  always_comb begin
    byte_done = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8);
    tx_load   = scl_fall && (((state == ST_ACK) && rd_mode) || (state == ST_TXNEXT));
    mem_hit   = (shreg[7:1] == {MEM_CODE, strap_i}) && !busy;
    ctl_hit   = (shreg[7:1] == {CTL_CODE, strap_i}) && !busy;
    rsv_hit   = (ptr >= AW'(RSV_LO)) && (ptr <= AW'(RSV_HI));
    cur_blk   = ptr[AW-1:OFFW];
    mem_we    = byte_done && (role == RL_DATA) && !lock_v[cur_blk] && !rsv_hit;
    ctl_wr    = byte_done && (role == RL_CTRL);
    ctl_idx   = shreg[BW-1:0];
    ctl_set   = shreg[7];
    rd_byte   = is_ctrl ? 8'(lock_v) : (rsv_hit ? 8'h00 : mem_rdata);
    wr_go     = stop_det && wrote;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      role     <= RL_DEV;
      bit_cnt  <= '0;
      shreg    <= '0;
      ptr      <= '0;
      is_ctrl  <= 1'b0;
      rd_mode  <= 1'b0;
      sda_oe_q <= 1'b0;
      wrote    <= 1'b0;
    end else if (tmo_fire || stop_det) begin
      state    <= ST_IDLE;
      sda_oe_q <= 1'b0;
      wrote    <= 1'b0;
    end else if (start_det) begin
      state    <= ST_RX;
      role     <= RL_DEV;
      bit_cnt  <= '0;
      sda_oe_q <= 1'b0;
    end else if (tx_load) begin
      // Drive the top bit of the next read byte
      sda_oe_q <= ~rd_byte[7];
      shreg    <= {rd_byte[6:0], 1'b0};
      bit_cnt  <= 4'd1;
      state    <= ST_TX;
      if (!is_ctrl) begin
        ptr <= ptr + 1'b1;
      end
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise && (bit_cnt != 4'd8)) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            sda_oe_q <= 1'b1;
            state    <= ST_ACK;
            unique case (role)
              RL_DEV: begin
                if (mem_hit || ctl_hit) begin
                  is_ctrl <= ctl_hit;
                  rd_mode <= shreg[0];
                  role    <= ctl_hit ? RL_CTRL : RL_AHI;
                end else begin
                  sda_oe_q <= 1'b0;
                  state    <= ST_WAIT;
                end
              end
              RL_AHI: begin
                ptr[AW-1:8] <= shreg[AW-9:0];
                role        <= RL_ALO;
              end
              RL_ALO: begin
                ptr[7:0] <= shreg;
                role     <= RL_DATA;
              end
              RL_DATA: begin
                ptr   <= ptr + 1'b1;
                wrote <= 1'b1;
              end
              RL_CTRL: begin
                wrote <= 1'b1;
              end
              default: begin
                state <= ST_WAIT;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_oe_q <= 1'b0;
            bit_cnt  <= '0;
            state    <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_oe_q <= 1'b0;
              state    <= ST_RACK;
            end else begin
              sda_oe_q <= ~shreg[7];
              shreg    <= {shreg[6:0], 1'b0};
              bit_cnt  <= bit_cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            state <= sda_s ? ST_WAIT : ST_TXNEXT;
          end
        end
        default: begin
        end
      endcase
    end
  end

  assign sda_oe = sda_oe_q;

endmodule

// File: rtl/prot_eeprom_chk.sv
module prot_eeprom_chk #(
  parameter int MEM_BYTES = 512,
  parameter int NBLK      = 4,
  parameter int RSV_LO    = 256,
  parameter int RSV_HI    = 319,
  localparam int AW       = $clog2(MEM_BYTES),
  localparam int BW       = $clog2(NBLK)
) (
  input logic            clk,
  input logic            rst,
  input logic            sda_oe,
  input logic            scl_s,
  input logic            stop_det,
  input logic            tmo_fire,
  input logic            busy,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic [NBLK-1:0] lock_v
);

  // R9
  reset_release_chk: assert property (@(posedge clk) rst |=> (!sda_oe && (lock_v == '0)));

  // R1
  drive_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R8
  tmo_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_fire |-> !scl_s);

  // R8
  tmo_release_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_fire |=> !sda_oe);

  // R7
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_det));

  // R6
  locked_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !lock_v[mem_addr[AW-1:AW-BW]]);

  // R4
  reserved_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !((mem_addr >= AW'(RSV_LO)) && (mem_addr <= AW'(RSV_HI))));

endmodule

bind prot_eeprom prot_eeprom_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .sda_oe   (sda_oe),
  .scl_s    (scl_s),
  .stop_det (stop_det),
  .tmo_fire (tmo_fire),
  .busy     (busy),
  .mem_we   (mem_we),
  .mem_addr (ptr),
  .lock_v   (lock_v)
);

// File: tb/prot_eeprom_bench.sv
module prot_eeprom_bench;

  localparam int Q       = 6;
  localparam int WR_CYC  = 1000;
  localparam int TMO_CYC = 1500;
  localparam logic [7:0] MEM_W = 8'hAA;
  localparam logic [7:0] MEM_R = 8'hAB;
  localparam logic [7:0] CTL_W = 8'h6A;
  localparam logic [7:0] CTL_R = 8'h6B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] rbuf [4];

  always #2.5 clk = ~clk;

  prot_eeprom #(.WR_CYCLES(WR_CYC), .TMO_CYCLES(TMO_CYC)) u_prot_eeprom (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_m),
    .sda_i   (sda_line),
    .strap_i (strap),
    .sda_oe  (sda_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq(); hq();
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
    end
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq();
    ack = ~sda_line;
    hq(); scl_m = 1'b0; hq();
  endtask

  task automatic rx_byte(output logic [7:0] b, input logic give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hq(); scl_m = 1'b1; hq();
      b[i] = sda_line;
      hq(); scl_m = 1'b0;
    end
    hq();
    sda_m = give_ack ? 1'b0 : 1'b1;
    hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
    sda_m = 1'b1;
  endtask

  task automatic wait_wr();
    repeat (WR_CYC + 40) @(negedge clk);
  endtask

  task automatic set_ptr(input logic [8:0] a);
    logic k;
    bus_start();
    tx_byte(MEM_W, k);
    tx_byte({7'b0, a[8]}, k);
    tx_byte(a[7:0], k);
  endtask

  task automatic wr_one(input logic [8:0] a, input logic [7:0] d, output logic ackd, input bit settle);
    set_ptr(a);
    tx_byte(d, ackd);
    bus_stop();
    if (settle) wait_wr();
  endtask

  task automatic rd_seq(input logic [8:0] a, input int n);
    logic k;
    set_ptr(a);
    bus_start();
    tx_byte(MEM_R, k);
    for (int j = 0; j < n; j++) rx_byte(rbuf[j], j != n - 1);
    bus_stop();
  endtask

  task automatic ctl_cmd(input logic [7:0] b);
    logic k;
    bus_start();
    tx_byte(CTL_W, k);
    tx_byte(b, k);
    bus_stop();
    wait_wr();
  endtask

  task automatic ctl_read(output logic [7:0] r);
    logic k;
    bus_start();
    tx_byte(CTL_R, k);
    rx_byte(r, 1'b0);
    bus_stop();
  endtask

  task automatic t_reset();
    logic [7:0] r;
    chk("R9 sda released after reset", sda_oe, 0);
    ctl_read(r);
    chk("R9 locks clear after reset", r, 8'h00);
  endtask

  task automatic t_address();
    logic a;
    bus_start();
    tx_byte(8'hA8, a);
    chk("R1 foreign address not acknowledged", a, 0);
    tx_byte(MEM_W, a);
    chk("R1 bus ignored after foreign address", a, 0);
    bus_stop();
    bus_start();
    tx_byte(MEM_W, a);
    chk("R1 memory address acknowledged", a, 1);
    bus_stop();
    bus_start();
    tx_byte(CTL_W, a);
    chk("R1 control address acknowledged", a, 1);
    bus_stop();
  endtask

  task automatic t_write_read();
    logic a;
    set_ptr(9'h010);
    tx_byte(8'hA1, a);
    chk("R2 first data byte acknowledged", a, 1);
    tx_byte(8'hB2, a);
    bus_stop();
    wait_wr();
    rd_seq(9'h010, 2);
    chk("R2 stored byte 0x010", rbuf[0], 8'hA1);
    chk("R3 sequential read 0x011", rbuf[1], 8'hB2);
    wr_one(9'h1A0, 8'hC3, a, 1);
    wr_one(9'h0A0, 8'h3C, a, 1);
    rd_seq(9'h1A0, 1);
    chk("R2 address bit 8 set", rbuf[0], 8'hC3);
    rd_seq(9'h0A0, 1);
    chk("R2 address bit 8 clear", rbuf[0], 8'h3C);
  endtask

  task automatic t_wrap();
    logic a;
    set_ptr(9'h1FF);
    tx_byte(8'h5A, a);
    tx_byte(8'h6B, a);
    bus_stop();
    wait_wr();
    rd_seq(9'h1FF, 2);
    chk("R3 last byte", rbuf[0], 8'h5A);
    chk("R3 pointer wraps to byte 0", rbuf[1], 8'h6B);
  endtask

  task automatic t_reserved();
    logic a;
    wr_one(9'h120, 8'h77, a, 1);
    rd_seq(9'h120, 1);
    chk("R4 reserved byte reads zero", rbuf[0], 8'h00);
    wr_one(9'h13F, 8'h12, a, 1);
    wr_one(9'h140, 8'h88, a, 1);
    wr_one(9'h0FF, 8'hEE, a, 1);
    rd_seq(9'h13F, 2);
    chk("R4 byte 319 reads zero", rbuf[0], 8'h00);
    chk("R4 byte 320 is storage", rbuf[1], 8'h88);
    rd_seq(9'h0FF, 1);
    chk("R4 byte 255 is storage", rbuf[0], 8'hEE);
  endtask

  task automatic t_protect();
    logic a;
    logic [7:0] r;
    wr_one(9'h0A0, 8'h22, a, 1);
    ctl_cmd(8'h81);
    ctl_read(r);
    chk("R5 lock block 1", r, 8'h02);
    wr_one(9'h0A0, 8'h11, a, 1);
    chk("R6 locked write acknowledged", a, 1);
    rd_seq(9'h0A0, 1);
    chk("R6 locked byte unchanged", rbuf[0], 8'h22);
    wr_one(9'h005, 8'h33, a, 1);
    rd_seq(9'h005, 1);
    chk("R6 open block 0 written", rbuf[0], 8'h33);
    ctl_cmd(8'h83);
    ctl_read(r);
    chk("R5 block 3 lock request ignored", r, 8'h02);
    wr_one(9'h1F0, 8'h99, a, 1);
    rd_seq(9'h1F0, 1);
    chk("R6 block 3 stays writable", rbuf[0], 8'h99);
    ctl_cmd(8'h82);
    ctl_read(r);
    chk("R5 lock block 2", r, 8'h06);
    wr_one(9'h150, 8'h5D, a, 1);
    rd_seq(9'h150, 1);
    chk("R6 locked block 2 discards data", rbuf[0] == 8'h5D, 0);
    ctl_cmd(8'h01);
    ctl_cmd(8'h02);
    ctl_read(r);
    chk("R5 locks cleared again", r, 8'h00);
    wr_one(9'h0A0, 8'h44, a, 1);
    rd_seq(9'h0A0, 1);
    chk("R5 unlocked block 1 written", rbuf[0], 8'h44);
  endtask

  task automatic t_busy();
    logic a;
    wr_one(9'h030, 8'h5C, a, 0);
    bus_start();
    tx_byte(MEM_W, a);
    chk("R7 memory address refused while busy", a, 0);
    bus_stop();
    bus_start();
    tx_byte(CTL_W, a);
    chk("R7 control address refused while busy", a, 0);
    bus_stop();
    wait_wr();
    bus_start();
    tx_byte(MEM_W, a);
    chk("R7 acknowledged after busy interval", a, 1);
    bus_stop();
    rd_seq(9'h030, 1);
    chk("R7 byte written before busy", rbuf[0], 8'h5C);
  endtask

  task automatic t_timeout();
    logic a;
    wr_one(9'h060, 8'h21, a, 1);
    set_ptr(9'h060);
    bus_stop();
    bus_start();
    tx_byte(MEM_R, a);
    repeat (20) @(negedge clk);
    chk("R8 block drives first bit low", sda_oe, 1);
    repeat (TMO_CYC + 20) @(negedge clk);
    chk("R8 SDA released after stuck SCL", sda_oe, 0);
    bus_stop();
    bus_start();
    tx_byte(MEM_W, a);
    chk("R8 served again after timeout", a, 1);
    bus_stop();
  endtask

  task automatic t_restart();
    logic a;
    logic [7:0] r;
    bus_start();
    tx_byte(MEM_W, a);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
    end
    bus_start();
    tx_byte(MEM_R, a);
    chk("R10 address after mid-byte start", a, 1);
    rx_byte(r, 1'b0);
    bus_stop();
  endtask

  task automatic t_nack();
    logic a;
    logic [7:0] r;
    set_ptr(9'h010);
    bus_start();
    tx_byte(MEM_R, a);
    rx_byte(r, 1'b0);
    chk("R11 byte before controller NACK", r, 8'hA1);
    rx_byte(r, 1'b0);
    chk("R11 silent after controller NACK", r, 8'hFF);
    chk("R11 SDA released", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    t_reset();
    t_address();
    t_write_read();
    t_wrap();
    t_reserved();
    t_protect();
    t_busy();
    t_timeout();
    t_restart();
    t_nack();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule